// File: doc/BRIEF.md
# Invalidate Queue with Early Acknowledge

This block sits between the coherence interconnect and the local cache of one processor. It takes in invalidate messages, each carrying a line address. It confirms each one in the same cycle it is written into a small in-order queue, so the requesting processor does not wait for the local cache to drop the line. The queued addresses are then handed to the cache one at a time through a valid/ready pair, whenever the cache can take them.

Because confirmation and invalidation are decoupled, a load can read a line that a remote writer already counts as invalidated. A read-barrier pulse closes that gap. It marks every entry held in the queue at that moment. From the next cycle, any load request is stalled until all of the marked entries have been handed to the cache. Entries that arrive later are left unmarked and never lengthen that stall. A full barrier drives this same input; its store-side half belongs to another block.

Top module: `invq_early_ack`

## Requirements
- R1: While reset is asserted and right after it, the queue is empty: `apply_vld` and `ld_stall` are 0, and `inv_ack` is 0 whenever `inv_vld` is 0.
- R2: When the queue holds fewer than DEPTH entries, `inv_ack` equals `inv_vld` in the same cycle, and the address on `inv_addr` is stored at that clock edge.
- R3: When the queue holds DEPTH entries, `inv_ack` stays 0 and nothing is stored, even if an apply retires an entry in that cycle. Acknowledgement resumes in the cycle after space has been freed.
- R4: `apply_vld` is 1 exactly while the queue is non-empty. `apply_addr` shows the oldest stored address, and entries leave in arrival order.
- R5: Each cycle with `apply_vld` and `apply_rdy` both high retires exactly one entry. While `apply_rdy` is low, `apply_addr` holds its value.
- R6: A cycle with `rd_bar` high marks every entry held at the start of that cycle, less one if an entry retires in that same cycle. From the following cycle on, `ld_stall` follows `ld_req` until every marked entry has retired.
- R7: An entry accepted in the barrier cycle or later is unmarked. The stall ends as soon as the last marked entry retires, even when unmarked entries remain.
- R8: A barrier seen while the queue is empty causes no stall.
- R9: `ld_stall` is never high while `ld_req` is low.
- R10: An accept and a retire in the same cycle both take effect, and occupancy stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| inv_vld | input | 1 | Incoming invalidate present; held until acknowledged |
| inv_addr | input | ADDR_W | Line address of the incoming invalidate |
| inv_ack | output | 1 | Invalidate accepted into the queue this cycle |
| apply_vld | output | 1 | A queued invalidate is waiting for the cache |
| apply_addr | output | ADDR_W | Oldest queued line address |
| apply_rdy | input | 1 | Cache takes the head entry this cycle |
| rd_bar | input | 1 | Read barrier (also driven by a full barrier), one-cycle pulse |
| ld_req | input | 1 | Load request from the core |
| ld_stall | output | 1 | Load must wait for marked entries to drain |

## Verification
Two activities can fall in the same cycle. First, an invalidate can be accepted while the head entry retires. Second, a barrier can be taken while an entry retires. The bench sets up both cases by holding `apply_rdy` high in the cycle that `inv_vld` or `rd_bar` is raised. For the first case, it drains the queue and counts the entries left, which must be the number held before. For the second, it checks that the stall lasts through exactly one further retire and no more.

// File: rtl/invq_pkg.sv
package invq_pkg;
  parameter int unsigned INVQ_ADDR_W_DEF = 32;
  parameter int unsigned INVQ_DEPTH_DEF  = 8;

  typedef enum logic [1:0] {
    OCC_HOLD = 2'b00,
    OCC_INC  = 2'b01,
    OCC_DEC  = 2'b10
  } occ_op_e;
endpackage

// File: rtl/invq_ring.sv
module invq_ring #(
  parameter int unsigned ADDR_W = invq_pkg::INVQ_ADDR_W_DEF,
  parameter int unsigned DEPTH  = invq_pkg::INVQ_DEPTH_DEF,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic [CNT_W-1:0]  occ,
  output logic              full,
  output logic              empty
);
  import invq_pkg::*;

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  occ_q, occ_d;
  occ_op_e           occ_op;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    if (push) wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
    rd_ptr_d = rd_ptr_q;
    if (pop) rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
    unique case ({push, pop})
      2'b10:   occ_op = OCC_INC;
      2'b01:   occ_op = OCC_DEC;
      default: occ_op = OCC_HOLD;
    endcase
    unique case (occ_op)
      OCC_INC: occ_d = occ_q + 1'b1;
      OCC_DEC: occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (wr_ptr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= push_addr;
    end
  end

  assign head_addr = slot_q[rd_ptr_q];
  assign occ       = occ_q;
  assign full      = (occ_q == FULL_CNT);
  assign empty     = (occ_q == '0);
endmodule

// File: rtl/invq_mark_ctr.sv
module invq_mark_ctr #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bar,
  input  logic             pop,
  input  logic [CNT_W-1:0] occ,
  output logic [CNT_W-1:0] marked,
  output logic             pending
);
  logic [CNT_W-1:0] marked_q, marked_d;
  logic             marked_en;

  always_comb begin
    marked_en = 1'b0;
    marked_d  = marked_q;
    if (bar) begin
      marked_en = 1'b1;
      marked_d  = occ - CNT_W'(pop);
    end else if (pop && (marked_q != '0)) begin
      marked_en = 1'b1;
      marked_d  = marked_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         marked_q <= '0;
    else if (marked_en) marked_q <= marked_d;
  end

  assign marked  = marked_q;
  assign pending = (marked_q != '0);
endmodule

// File: rtl/invq_early_ack.sv
module invq_early_ack #(
  parameter int unsigned ADDR_W = invq_pkg::INVQ_ADDR_W_DEF,
  parameter int unsigned DEPTH  = invq_pkg::INVQ_DEPTH_DEF,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_vld,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              inv_ack,
  output logic              apply_vld,
  output logic [ADDR_W-1:0] apply_addr,
  input  logic              apply_rdy,
  input  logic              rd_bar,
  input  logic              ld_req,
  output logic              ld_stall
);
  logic             accept;
  logic             retire;
  logic             q_full;
  logic             q_empty;
  logic [CNT_W-1:0] occ;
  logic [CNT_W-1:0] marked_cnt;
  logic             mark_pending;

  assign accept = inv_vld && !q_full;
  assign retire = !q_empty && apply_rdy;

  invq_ring #(
    .ADDR_W(ADDR_W),
    .DEPTH (DEPTH)
  ) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .push_addr(inv_addr),
    .pop      (retire),
    .head_addr(apply_addr),
    .occ      (occ),
    .full     (q_full),
    .empty    (q_empty)
  );

  invq_mark_ctr #(
    .CNT_W(CNT_W)
  ) u_mark (
    .clk    (clk),
    .rst_n  (rst_n),
    .bar    (rd_bar),
    .pop    (retire),
    .occ    (occ),
    .marked (marked_cnt),
    .pending(mark_pending)
  );

  assign inv_ack   = accept;
  assign apply_vld = !q_empty;
  assign ld_stall  = ld_req && mark_pending;
endmodule

// File: rtl/invq_checks.sv
module invq_checks #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inv_vld,
  input logic              inv_ack,
  input logic              apply_vld,
  input logic [ADDR_W-1:0] apply_addr,
  input logic              apply_rdy,
  input logic              rd_bar,
  input logic              ld_req,
  input logic              ld_stall,
  input logic [CNT_W-1:0]  occ,
  input logic [CNT_W-1:0]  marked_cnt
);
  logic [CNT_W-1:0] mdl_occ;
  logic             mdl_in;
  logic             mdl_out;

  assign mdl_in  = inv_ack;
  assign mdl_out = apply_vld && apply_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdl_occ <= '0;
    else        mdl_occ <= mdl_occ + CNT_W'(mdl_in) - CNT_W'(mdl_out);
  end

  AST_ACK_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    inv_ack |-> inv_vld); // R2
  AST_NO_ACK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (mdl_occ == CNT_W'(DEPTH)) |-> !inv_ack); // R3
  AST_APPLY_MATCHES_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    apply_vld == (mdl_occ != '0)); // R4
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_vld && !apply_rdy) |=> (apply_vld && $stable(apply_addr))); // R5
  AST_MARK_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    marked_cnt <= mdl_occ); // R7
  AST_BARRIER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_bar && (mdl_occ == '0)) |=> (marked_cnt == '0)); // R8
  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> ld_req); // R9
  AST_SAME_CYCLE_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_ack && apply_vld && apply_rdy) |=> $stable(occ)); // R10
endmodule

bind invq_early_ack invq_checks #(
  .ADDR_W(ADDR_W),
  .DEPTH (DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inv_vld   (inv_vld),
  .inv_ack   (inv_ack),
  .apply_vld (apply_vld),
  .apply_addr(apply_addr),
  .apply_rdy (apply_rdy),
  .rd_bar    (rd_bar),
  .ld_req    (ld_req),
  .ld_stall  (ld_stall),
  .occ       (occ),
  .marked_cnt(marked_cnt)
);

// File: tb/sim_invq_early_ack.sv
module sim_invq_early_ack;
  localparam int unsigned AW = 16;
  localparam int unsigned D  = 4;

  logic          clk;
  logic          rst_n;
  logic          inv_vld;
  logic [AW-1:0] inv_addr;
  logic          inv_ack;
  logic          apply_vld;
  logic [AW-1:0] apply_addr;
  logic          apply_rdy;
  logic          rd_bar;
  logic          ld_req;
  logic          ld_stall;

  int n_chk;
  int n_fail;
  bit done;

  invq_early_ack #(.ADDR_W(AW), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n),
    .inv_vld(inv_vld), .inv_addr(inv_addr), .inv_ack(inv_ack),
    .apply_vld(apply_vld), .apply_addr(apply_addr), .apply_rdy(apply_rdy),
    .rd_bar(rd_bar), .ld_req(ld_req), .ld_stall(ld_stall)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic t_reset();
    inv_vld = 0; inv_addr = '0; apply_rdy = 0; rd_bar = 0; ld_req = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 apply_vld in reset", 32'(apply_vld), 0);
    chk("R1 ld_stall in reset", 32'(ld_stall), 0);
    chk("R1 inv_ack in reset", 32'(inv_ack), 0);
    @(negedge clk);
    rst_n = 1;
    step();
    ld_req = 1; #1;
    chk("R1 empty after reset", 32'(apply_vld), 0);
    chk("R1 no stall after reset", 32'(ld_stall), 0);
    ld_req = 0;
  endtask

  task automatic t_fill_order();
    for (int i = 0; i < D; i++) begin
      inv_vld = 1; inv_addr = AW'(16'h100 + i); #1;
      chk("R2 ack while space", 32'(inv_ack), 1);
      step();
    end
    inv_addr = 16'h200; apply_rdy = 0; #1;
    chk("R3 no ack when full", 32'(inv_ack), 0);
    chk("R4 head is oldest", 32'(apply_addr), 32'h100);
    step();
    chk("R5 head held while not ready", 32'(apply_addr), 32'h100);
    apply_rdy = 1; #1;
    chk("R3 no ack in freeing cycle", 32'(inv_ack), 0);
    step();
    apply_rdy = 0; #1;
    chk("R3 ack resumes after space freed", 32'(inv_ack), 1);
    step();
    inv_vld = 0;
    for (int i = 0; i < D; i++) begin
      logic [31:0] exp;
      exp = (i == D - 1) ? 32'h200 : 32'(16'h101 + i);
      apply_rdy = 1; #1;
      chk("R4 apply_vld while non-empty", 32'(apply_vld), 1);
      chk("R4 arrival order", 32'(apply_addr), exp);
      step();
    end
    apply_rdy = 0; #1;
    chk("R4 empty after drain", 32'(apply_vld), 0);
  endtask

  task automatic t_barrier();
    for (int i = 0; i < 3; i++) begin
      inv_vld = 1; inv_addr = AW'(16'h10 + i);
      step();
    end
    rd_bar = 1; inv_addr = 16'h13; ld_req = 1; #1;
    chk("R6 no stall in barrier cycle", 32'(ld_stall), 0);
    step();
    rd_bar = 0; inv_addr = 16'h14; #1;
    chk("R6 stall after barrier", 32'(ld_stall), 1);
    step();
    inv_vld = 0;
    for (int i = 0; i < 3; i++) begin
      apply_rdy = 1; #1;
      chk("R6 stall while marked remain", 32'(ld_stall), 1);
      step();
    end
    apply_rdy = 0; #1;
    chk("R7 stall ends with unmarked left", 32'(ld_stall), 0);
    chk("R7 unmarked entry still queued", 32'(apply_addr), 32'h13);
    ld_req = 0;
    apply_rdy = 1;
    step(); step();
    apply_rdy = 0; #1;
    chk("R4 empty after barrier test", 32'(apply_vld), 0);
  endtask

  task automatic t_empty_barrier();
    rd_bar = 1;
    step();
    rd_bar = 0; ld_req = 1; #1;
    chk("R8 barrier on empty queue", 32'(ld_stall), 0);
    ld_req = 0;
    inv_vld = 1; inv_addr = 16'h30;
    step();
    inv_vld = 0; rd_bar = 1;
    step();
    rd_bar = 0; ld_req = 0; #1;
    chk("R9 no stall without load", 32'(ld_stall), 0);
    ld_req = 1; #1;
    chk("R6 stall with load", 32'(ld_stall), 1);
    apply_rdy = 1;
    step();
    apply_rdy = 0; #1;
    chk("R6 stall clears after apply", 32'(ld_stall), 0);
    ld_req = 0;
  endtask

  task automatic t_same_cycle();
    inv_vld = 1; inv_addr = 16'h20; step();
    inv_addr = 16'h21; step();
    inv_addr = 16'h22; apply_rdy = 1; #1;
    chk("R10 accept during retire", 32'(inv_ack), 1);
    chk("R10 retiring head", 32'(apply_addr), 32'h20);
    step();
    inv_vld = 0; apply_rdy = 0; #1;
    chk("R10 next head", 32'(apply_addr), 32'h21);
    rd_bar = 1; apply_rdy = 1;
    step();
    rd_bar = 0; apply_rdy = 0; ld_req = 1; #1;
    chk("R6 one marked left after same-cycle retire", 32'(ld_stall), 1);
    chk("R10 third entry present", 32'(apply_addr), 32'h22);
    apply_rdy = 1;
    step();
    apply_rdy = 0; #1;
    chk("R6 stall ends after last marked", 32'(ld_stall), 0);
    chk("R10 occupancy preserved", 32'(apply_vld), 0);
    ld_req = 0;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    t_reset();
    t_fill_order();
    t_barrier();
    t_empty_barrier();
    t_same_cycle();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finish_run();
    end
  end
endmodule